// File: doc/BRIEF.md
# SDRAM Pin Retiming Stage for Registered Memory

This block sits between the command sequencer of an SDRAM controller and the controller's output pins. It exists so that one sequencer design can drive both unbuffered and registered DIMMs, as well as an external data multiplexer that interleaves two physical DIMMs two ways. Four configuration bits each add one clock of delay to their own group of signals. The four groups are the read-data capture strobe, the select and two clock enables of the external multiplexer, the write-data drive window, and the command, address and bank-select outputs.

When a bit is clear, its group passes straight through with no added latency. When a bit is set, its group comes from a register in the same clock domain, so the pin holds the sequencer value from the previous cycle. The write group works differently. Its bit does not delay the data. It stretches the drive window instead, so the data bus keeps the last beat of a burst for one extra cycle after the sequencer stops driving. Configuration may change only while the sequencer is idle.

Top module: `sdram_pin_retimer`

## Requirements
- R1: With cfgWord equal to 0, every output equals its input in the same cycle.
- R2: cfgWord bit 0 set: pinRdCapture equals seqRdCapture from one clock earlier.
- R3: cfgWord bit 1 set: pinMuxSel and both bits of pinMuxCke equal their inputs from one clock earlier.
- R4: cfgWord bit 2 set: in the first cycle after seqWrEn falls, pinWrOe stays 1 and pinWrData shows the last beat driven. While seqWrEn is 1, pinWrOe is 1 and pinWrData equals seqWrData.
- R5: cfgWord bit 3 set: pinRasN, pinCasN, pinWeN, pinAddrLo, pinAddrHi and pinBank equal their inputs from one clock earlier.
- R6: Each cfgWord bit acts only on its own group. All 16 settings give each group the behaviour of its own bit alone.
- R7: While rstN is 0, the delayed command group reads all ones, the delayed multiplexer group and read strobe read 0, and the write window is not extended. Where a group is delayed, the first cycle after reset shows these values.
- R8: A delayed output changes only at a clock edge. Between edges it does not follow its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 4 | bit0 read delay, bit1 mux delay, bit2 write hold, bit3 command delay |
| seqRdCapture | input | 1 | Read capture strobe from the sequencer |
| seqMuxSel | input | 1 | External mux select from the sequencer |
| seqMuxCke | input | 2 | External mux clock enables from the sequencer |
| seqWrData | input | DATA_W | Write data from the sequencer |
| seqWrEn | input | 1 | Write data drive enable from the sequencer |
| seqRasN | input | 2 | RAS per rank, active low |
| seqCasN | input | 2 | CAS per rank, active low |
| seqWeN | input | 2 | WE per rank, active low |
| seqAddrLo | input | 2 | Low address bit copies: bit0 even side, bit1 odd side |
| seqAddrHi | input | ADDR_W-1 | Upper address bits |
| seqBank | input | 2 | Bank selects |
| pinRdCapture | output | 1 | Retimed read capture strobe |
| pinMuxSel | output | 1 | Retimed mux select |
| pinMuxCke | output | 2 | Retimed mux clock enables |
| pinWrData | output | DATA_W | Write data to memory |
| pinWrOe | output | 1 | Write data output enable |
| pinRasN | output | 2 | Retimed RAS |
| pinCasN | output | 2 | Retimed CAS |
| pinWeN | output | 2 | Retimed WE |
| pinAddrLo | output | 2 | Retimed low address copies |
| pinAddrHi | output | ADDR_W-1 | Retimed upper address |
| pinBank | output | 2 | Retimed bank selects |

## Verification
A group whose bit is clear must show its result in the cycle its input is driven. A group whose bit is set must show, at the next edge, the value driven in the previous cycle. The write window closes one cycle after seqWrEn falls. The bench drives inputs just after each rising edge and compares at the following falling edge. It keeps its own record of the previous cycle's stimulus, so every expected value is either the current or the previous input. Before the first edge after reset, that record holds the reset values. All 16 configurations are swept with pseudo-random traffic, and all four groups are checked in every cycle.

// File: rtl/rdimm_shift_pkg.sv
package rdimm_shift_pkg;
  localparam int CFG_W   = 4;
  localparam int RD_BIT  = 0;
  localparam int MUX_BIT = 1;
  localparam int WR_BIT  = 2;
  localparam int CMD_BIT = 3;

  typedef struct packed {
    logic rdDly;
    logic muxDly;
    logic wrExtend;
    logic cmdDly;
  } shiftStrobes_t;
endpackage

// File: rtl/opt_delay.sv
module opt_delay #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         useDelay,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) held <= RST_VAL;
    else       held <= d;
  end

  assign q = useDelay ? held : d;
endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import rdimm_shift_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             seqWrEn,
  output shiftStrobes_t    strobes
);
  logic wasEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wasEn <= 1'b0;
    else       wasEn <= seqWrEn;
  end

  always_comb begin
    strobes.rdDly    = cfgWord[RD_BIT];
    strobes.muxDly   = cfgWord[MUX_BIT];
    strobes.cmdDly   = cfgWord[CMD_BIT];
    strobes.wrExtend = cfgWord[WR_BIT] & wasEn & ~seqWrEn;
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import rdimm_shift_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobes_t     strobes,
  input  logic              seqRdCapture,
  input  logic              seqMuxSel,
  input  logic [1:0]        seqMuxCke,
  input  logic [DATA_W-1:0] seqWrData,
  input  logic              seqWrEn,
  input  logic [1:0]        seqRasN,
  input  logic [1:0]        seqCasN,
  input  logic [1:0]        seqWeN,
  input  logic [1:0]        seqAddrLo,
  input  logic [ADDR_W-2:0] seqAddrHi,
  input  logic [1:0]        seqBank,
  output logic              pinRdCapture,
  output logic              pinMuxSel,
  output logic [1:0]        pinMuxCke,
  output logic [DATA_W-1:0] pinWrData,
  output logic              pinWrOe,
  output logic [1:0]        pinRasN,
  output logic [1:0]        pinCasN,
  output logic [1:0]        pinWeN,
  output logic [1:0]        pinAddrLo,
  output logic [ADDR_W-2:0] pinAddrHi,
  output logic [1:0]        pinBank
);
  localparam int MUX_W = 3;
  localparam int CMD_W = 10 + (ADDR_W - 1);

  logic [CMD_W-1:0]  cmdIn, cmdOut;
  logic [MUX_W-1:0]  muxOut;
  logic [DATA_W-1:0] lastData;

  opt_delay #(.W(1), .RST_VAL(1'b0)) u_rd (
    .clk(clk), .rstN(rstN), .useDelay(strobes.rdDly),
    .d(seqRdCapture), .q(pinRdCapture)
  );

  opt_delay #(.W(MUX_W), .RST_VAL('0)) u_mux (
    .clk(clk), .rstN(rstN), .useDelay(strobes.muxDly),
    .d({seqMuxSel, seqMuxCke}), .q(muxOut)
  );
  assign {pinMuxSel, pinMuxCke} = muxOut;

  assign cmdIn = {seqRasN, seqCasN, seqWeN, seqAddrLo, seqAddrHi, seqBank};
  opt_delay #(.W(CMD_W), .RST_VAL({CMD_W{1'b1}})) u_cmd (
    .clk(clk), .rstN(rstN), .useDelay(strobes.cmdDly),
    .d(cmdIn), .q(cmdOut)
  );
  assign {pinRasN, pinCasN, pinWeN, pinAddrLo, pinAddrHi, pinBank} = cmdOut;

  // last beat of the current burst, held for the stretched cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lastData <= '0;
    else if (seqWrEn) lastData <= seqWrData;
  end

  assign pinWrOe   = seqWrEn | strobes.wrExtend;
  assign pinWrData = strobes.wrExtend ? lastData : seqWrData;
endmodule

// File: rtl/sdram_pin_retimer.sv
module sdram_pin_retimer
  import rdimm_shift_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        cfgWord,
  input  logic              seqRdCapture,
  input  logic              seqMuxSel,
  input  logic [1:0]        seqMuxCke,
  input  logic [DATA_W-1:0] seqWrData,
  input  logic              seqWrEn,
  input  logic [1:0]        seqRasN,
  input  logic [1:0]        seqCasN,
  input  logic [1:0]        seqWeN,
  input  logic [1:0]        seqAddrLo,
  input  logic [ADDR_W-2:0] seqAddrHi,
  input  logic [1:0]        seqBank,
  output logic              pinRdCapture,
  output logic              pinMuxSel,
  output logic [1:0]        pinMuxCke,
  output logic [DATA_W-1:0] pinWrData,
  output logic              pinWrOe,
  output logic [1:0]        pinRasN,
  output logic [1:0]        pinCasN,
  output logic [1:0]        pinWeN,
  output logic [1:0]        pinAddrLo,
  output logic [ADDR_W-2:0] pinAddrHi,
  output logic [1:0]        pinBank
);
  shiftStrobes_t strobes;

  shift_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord),
    .seqWrEn(seqWrEn), .strobes(strobes)
  );

  shift_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .seqRdCapture(seqRdCapture), .seqMuxSel(seqMuxSel), .seqMuxCke(seqMuxCke),
    .seqWrData(seqWrData), .seqWrEn(seqWrEn),
    .seqRasN(seqRasN), .seqCasN(seqCasN), .seqWeN(seqWeN),
    .seqAddrLo(seqAddrLo), .seqAddrHi(seqAddrHi), .seqBank(seqBank),
    .pinRdCapture(pinRdCapture), .pinMuxSel(pinMuxSel), .pinMuxCke(pinMuxCke),
    .pinWrData(pinWrData), .pinWrOe(pinWrOe),
    .pinRasN(pinRasN), .pinCasN(pinCasN), .pinWeN(pinWeN),
    .pinAddrLo(pinAddrLo), .pinAddrHi(pinAddrHi), .pinBank(pinBank)
  );
endmodule

// File: rtl/shift_checker.sv
module shift_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        cfgWord,
  input logic              seqRdCapture,
  input logic              seqMuxSel,
  input logic [1:0]        seqMuxCke,
  input logic [DATA_W-1:0] seqWrData,
  input logic              seqWrEn,
  input logic [1:0]        seqRasN,
  input logic [1:0]        seqCasN,
  input logic [1:0]        seqWeN,
  input logic [1:0]        seqAddrLo,
  input logic [ADDR_W-2:0] seqAddrHi,
  input logic [1:0]        seqBank,
  input logic              pinRdCapture,
  input logic              pinMuxSel,
  input logic [1:0]        pinMuxCke,
  input logic [DATA_W-1:0] pinWrData,
  input logic              pinWrOe,
  input logic [1:0]        pinRasN,
  input logic [1:0]        pinCasN,
  input logic [1:0]        pinWeN,
  input logic [1:0]        pinAddrLo,
  input logic [ADDR_W-2:0] pinAddrHi,
  input logic [1:0]        pinBank
);
  logic armed;
  logic [10+ADDR_W-2:0] cmdIn, cmdPin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assign cmdIn  = {seqRasN, seqCasN, seqWeN, seqAddrLo, seqAddrHi, seqBank};
  assign cmdPin = {pinRasN, pinCasN, pinWeN, pinAddrLo, pinAddrHi, pinBank};

  p_zero_lat_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord == 4'd0) |-> (pinRdCapture == seqRdCapture && pinMuxSel == seqMuxSel
      && pinMuxCke == seqMuxCke && pinWrData == seqWrData && pinWrOe == seqWrEn
      && cmdPin == cmdIn));

  p_rd_delay_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cfgWord[0]) |-> (pinRdCapture == $past(seqRdCapture)));

  p_mux_delay_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cfgWord[1]) |-> ({pinMuxSel, pinMuxCke} == $past({seqMuxSel, seqMuxCke})));

  p_wr_stretch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cfgWord[2] && $past(seqWrEn) && !seqWrEn)
      |-> (pinWrOe && pinWrData == $past(seqWrData)));

  p_wr_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    seqWrEn |-> (pinWrOe && pinWrData == seqWrData));

  p_cmd_delay_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cfgWord[3]) |-> (cmdPin == $past(cmdIn)));

  p_cmd_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cfgWord[3] && $past(cfgWord[3])) |=> $stable(cmdPin) || cmdPin == $past(cmdIn));
endmodule

bind sdram_pin_retimer shift_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_sdram_pin_retimer.sv
module test_sdram_pin_retimer;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 14;
  localparam int CMD_W  = 10 + ADDR_W - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] cfgWord = 4'hF;
  logic seqRdCapture = 1'b0, seqMuxSel = 1'b0, seqWrEn = 1'b0;
  logic [1:0] seqMuxCke = '0, seqRasN = '0, seqCasN = '0, seqWeN = '0, seqAddrLo = '0, seqBank = '0;
  logic [DATA_W-1:0] seqWrData = '0;
  logic [ADDR_W-2:0] seqAddrHi = '0;
  logic pinRdCapture, pinMuxSel, pinWrOe;
  logic [1:0] pinMuxCke, pinRasN, pinCasN, pinWeN, pinAddrLo, pinBank;
  logic [DATA_W-1:0] pinWrData;
  logic [ADDR_W-2:0] pinAddrHi;

  int nChecks = 0, nFails = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  // previous-cycle record of the stimulus, as seen by the pins' registers
  logic prvRd, prvEn;
  logic [2:0] prvMux;
  logic [CMD_W-1:0] prvCmd;
  logic [DATA_W-1:0] prvData;

  always #2 clk = ~clk;

  sdram_pin_retimer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_sdram_pin_retimer (.*);

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s cfg=%h got=%h exp=%h", tag, cfgWord, got, exp);
    end
  endtask

  function automatic logic [CMD_W-1:0] curCmd();
    return {seqRasN, seqCasN, seqWeN, seqAddrLo, seqAddrHi, seqBank};
  endfunction

  task automatic stepLfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic driveRandom(input logic allowWr);
    stepLfsr();
    seqRdCapture = lfsr[0];
    {seqMuxSel, seqMuxCke} = lfsr[3:1];
    {seqRasN, seqCasN, seqWeN, seqAddrLo} = lfsr[11:4];
    seqBank = lfsr[13:12];
    stepLfsr();
    seqAddrHi = lfsr[ADDR_W-2:0];
    seqWrData = lfsr[31:16];
    seqWrEn = allowWr & (lfsr[14] | lfsr[15]);
  endtask

  task automatic checkAll();
    logic [CMD_W-1:0] expCmd;
    logic expOe;
    logic [DATA_W-1:0] expData;
    expCmd = cfgWord[3] ? prvCmd : curCmd();
    expOe = seqWrEn | (cfgWord[2] & prvEn);
    expData = (!seqWrEn && cfgWord[2] && prvEn) ? prvData : seqWrData;
    // R1 when cfg is zero; R6 since every group is checked under every setting
    check(cfgWord == 0 ? "R1 R6 read" : "R2 R6 read", 64'(pinRdCapture),
          64'(cfgWord[0] ? prvRd : seqRdCapture));
    check(cfgWord == 0 ? "R1 R6 mux" : "R3 R6 mux", 64'({pinMuxSel, pinMuxCke}),
          64'(cfgWord[1] ? prvMux : {seqMuxSel, seqMuxCke}));
    check(cfgWord == 0 ? "R1 R6 write" : "R4 R6 write", 64'({pinWrOe, pinWrData}),
          64'({expOe, expData}));
    check(cfgWord == 0 ? "R1 R6 cmd" : "R5 R8 cmd",
          64'({pinRasN, pinCasN, pinWeN, pinAddrLo, pinAddrHi, pinBank}), 64'(expCmd));
  endtask

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    prvRd = 1'b0; prvMux = '0; prvCmd = '1; prvEn = 1'b0; prvData = '0;
    // reset state with all delays selected (R7)
    seqRdCapture = 1'b1; {seqMuxSel, seqMuxCke} = 3'b111;
    {seqRasN, seqCasN, seqWeN, seqAddrLo, seqBank} = '0; seqAddrHi = '0;
    seqWrEn = 1'b0; seqWrData = 16'hA5A5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset read", 64'(pinRdCapture), 64'd0);
    check("R7 reset mux", 64'({pinMuxSel, pinMuxCke}), 64'd0);
    check("R7 reset cmd", 64'({pinRasN, pinCasN, pinWeN, pinAddrLo, pinAddrHi, pinBank}),
          64'({CMD_W{1'b1}}));
    check("R7 reset write", 64'(pinWrOe), 64'd0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    check("R7 first cycle cmd", 64'({pinRasN, pinCasN, pinWeN, pinAddrLo, pinAddrHi, pinBank}),
          64'({CMD_W{1'b1}}));
    checkAll();

    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 60; k++) begin
        @(posedge clk);
        prvRd = seqRdCapture; prvMux = {seqMuxSel, seqMuxCke}; prvCmd = curCmd();
        prvEn = seqWrEn; prvData = seqWrData;
        #1;
        if (k == 0) cfgWord = 4'(c);
        driveRandom(k > 1 && k < 58);
        @(negedge clk);
        checkAll();
      end
    end

    // single-beat and back-to-back write bursts with stretching on (R4)
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      prvRd = seqRdCapture; prvMux = {seqMuxSel, seqMuxCke}; prvCmd = curCmd();
      prvEn = seqWrEn; prvData = seqWrData;
      #1;
      if (k == 0) cfgWord = 4'b0100;
      seqWrEn = (k == 2) || (k == 4) || (k == 5);
      seqWrData = 16'h1000 + 16'(k);
      @(negedge clk);
      checkAll();
      if (k == 3) check("R4 single-beat stretch", 64'({pinWrOe, pinWrData}), 64'({1'b1, 16'h1002}));
      if (k == 7) check("R4 window closed", 64'(pinWrOe), 64'd0);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule